// File: doc/BRIEF.md
# Passive LCD panel timing generator

This block turns one or two streams of pixel words into the signals a passive-matrix LCD panel needs. It produces a gated shift clock, a line-load strobe, a frame-start strobe and an AC-bias output, and it places pixel bits on a data bus of full or half width. In single-scan operation, one source fills the bus. In dual-scan operation, the bus is split between two sources. One source feeds the upper half of the screen and the other feeds the lower half, so two rows are shifted together. Each frame then covers half the panel's row count.

The shift clock is derived from the system clock by a programmable divider and runs only while a line is being shifted. After the last shift of a line, the load strobe transfers the line into the panel's drive latches. The frame strobe covers the first line of every frame. The AC-bias output toggles after a programmable number of frames. Each output has its own polarity bit. Height, divider, AC count and mode are sampled once after reset and again at every frame boundary. Width and mode are changed only under reset.

Top module: `lcd_passive_tgen`

## Requirements
- R1: While rst_ni is low, `ld_o` is 0, both ready outputs are 0, and every strobe output sits at its inactive level.
- R2: Each shift pulse is active for exactly clk_div_i+1 clocks. `ld_o` takes its new word at least clk_div_i+1 clocks before the shift goes active, and it does not change while the shift is active.
- R3: Each line has a fixed number of shift pulses between two load pulses. That number is panel_w_i divided by the pixels per transfer: 8 for single wide, 4 for single narrow, 4 for dual wide and 2 for dual narrow. bus_wide_i=1 selects the full 8-bit bus.
- R4: The bus word depends on the mode.
  - Single wide: `ld_o` = up_pix_i.
  - Single narrow: `ld_o` = {0000, up_pix_i[3:0]}.
  - Dual wide: `ld_o` = {up_pix_i[3:0], lo_pix_i[3:0]}.
  - Dual narrow: `ld_o` = {0000, up_pix_i[1:0], lo_pix_i[1:0]}.
- R5: The lower source is accepted only in dual mode. It is accepted in the same cycle as the upper source and only when lo_valid_i is high.
- R6: The frame strobe goes active on the same edge as the load pulse of the first line. It goes inactive on the load edge of the next line. The number of load pulses per frame is panel_h_i in single mode and panel_h_i/2 in dual mode (at least 2).
- R7: The AC-bias output toggles once every ac_frames_i frames, with 0 treated as 1. It toggles at a frame boundary, never while a shift or load is active.
- R8: Each strobe output equals its active level XOR its polarity bit, so a polarity bit of 1 makes that output active-low.
- R9: Changes to panel_h_i, clk_div_i or ac_frames_i in the middle of a frame leave the current frame unchanged and take effect from the next frame.
- R10: No shift pulse occurs without an accepted pixel transfer. When no data is offered, shifting stops, and it resumes once data is offered again.
- R11: Each load pulse is active for clk_div_i+1 clocks, and the shift clock is inactive throughout the load pulse and for the tick that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dual_i | input | 1 | 1 selects dual-scan operation |
| bus_wide_i | input | 1 | 1 selects the full 8-bit bus, 0 the 4-bit bus |
| panel_w_i | input | W_W | Panel width in pixels, a multiple of 8 |
| panel_h_i | input | H_W | Panel height in rows |
| clk_div_i | input | DIV_W | A tick occurs every clk_div_i+1 clocks |
| ac_frames_i | input | AC_W | Frames between AC-bias toggles |
| pol_shift_i | input | 1 | Shift output polarity |
| pol_load_i | input | 1 | Load output polarity |
| pol_frame_i | input | 1 | Frame output polarity |
| pol_ac_i | input | 1 | AC-bias output polarity |
| up_pix_i | input | BUS_W | Upper-half (or only) pixel word |
| up_valid_i | input | 1 | Upper word valid |
| up_ready_o | output | 1 | Upper word accepted this cycle |
| lo_pix_i | input | BUS_W/2 | Lower-half pixel word |
| lo_valid_i | input | 1 | Lower word valid |
| lo_ready_o | output | 1 | Lower word accepted this cycle |
| shift_o | output | 1 | Panel shift clock |
| load_o | output | 1 | Line-load strobe |
| frame_o | output | 1 | Frame-start strobe |
| acb_o | output | 1 | AC-bias output |
| ld_o | output | BUS_W | Panel data bus |

## Verification
The assertions assume the following about the block's inputs:
- Each source holds its valid and data until the word is accepted.
- Polarity bits stay constant outside reset.
- The panel width is a multiple of 8.
- Each frame has at least two rows.

The stimulus keeps within these limits. The sources raise valid at random times and drop it only after a handshake. Polarity, mode and width change only while reset is held. The mid-frame configuration change is applied a few cycles after a frame start, so it cannot land between the last load and the frame wrap.

// File: rtl/lcd_pkg.sv
package lcd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DATA,
    ST_HOLD,
    ST_SHIFT,
    ST_LOAD,
    ST_GAP
  } lcd_st_e;
endpackage

// File: rtl/lcd_tick_div.sv
module lcd_tick_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] limit_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  // >= tolerates a limit that shrinks at a frame boundary
  assign tick_o = (cnt_q >= limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/lcd_bus_pack.sv
module lcd_bus_pack #(
  parameter int BUS_W = 8
) (
  input  logic                 dual_i,
  input  logic                 wide_i,
  input  logic [BUS_W-1:0]     up_i,
  input  logic [BUS_W/2-1:0]   lo_i,
  output logic [BUS_W-1:0]     ld_o
);
  localparam int HALF_W = BUS_W / 2;
  localparam int QTR_W  = BUS_W / 4;

  always_comb begin
    ld_o = '0;
    unique case ({dual_i, wide_i})
      2'b01:   ld_o = up_i;
      2'b00:   ld_o[HALF_W-1:0] = up_i[HALF_W-1:0];
      2'b11:   ld_o = {up_i[HALF_W-1:0], lo_i};
      default: ld_o[HALF_W-1:0] = {up_i[QTR_W-1:0], lo_i[QTR_W-1:0]};
    endcase
  end
endmodule

// File: rtl/lcd_ac_bias.sv
module lcd_ac_bias #(
  parameter int AC_W = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            frame_end_i,
  input  logic [AC_W-1:0] limit_i,
  output logic            ac_o
);
  logic [AC_W-1:0] cnt_q;
  logic [AC_W:0]   cnt_nxt;

  assign cnt_nxt = {1'b0, cnt_q} + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ac_o  <= 1'b0;
    end else if (frame_end_i) begin
      // limit 0 behaves as 1
      if (cnt_nxt >= {1'b0, limit_i}) begin
        cnt_q <= '0;
        ac_o  <= ~ac_o;
      end else begin
        cnt_q <= cnt_nxt[AC_W-1:0];
      end
    end
  end
endmodule

// File: rtl/lcd_passive_tgen.sv
module lcd_passive_tgen
  import lcd_pkg::*;
#(
  parameter int BUS_W = 8,
  parameter int W_W   = 10,
  parameter int H_W   = 10,
  parameter int DIV_W = 8,
  parameter int AC_W  = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               dual_i,
  input  logic               bus_wide_i,
  input  logic [W_W-1:0]     panel_w_i,
  input  logic [H_W-1:0]     panel_h_i,
  input  logic [DIV_W-1:0]   clk_div_i,
  input  logic [AC_W-1:0]    ac_frames_i,
  input  logic               pol_shift_i,
  input  logic               pol_load_i,
  input  logic               pol_frame_i,
  input  logic               pol_ac_i,
  input  logic [BUS_W-1:0]   up_pix_i,
  input  logic               up_valid_i,
  output logic               up_ready_o,
  input  logic [BUS_W/2-1:0] lo_pix_i,
  input  logic               lo_valid_i,
  output logic               lo_ready_o,
  output logic               shift_o,
  output logic               load_o,
  output logic               frame_o,
  output logic               acb_o,
  output logic [BUS_W-1:0]   ld_o
);
  localparam int SH_FULL = $clog2(BUS_W);
  localparam int SH_HALF = $clog2(BUS_W / 2);
  localparam int SH_QTR  = $clog2(BUS_W / 4);

  lcd_st_e            st_q, st_d;
  logic               dual_q, wide_q;
  logic [W_W-1:0]     width_q, col_q, xfers;
  logic [H_W-1:0]     height_q, row_q, rows;
  logic [DIV_W-1:0]   div_q;
  logic [AC_W-1:0]    ac_q;
  logic               tick, data_ok, fire, last_col, last_row, frame_end, cfg_load;
  logic               shift_q, load_q, frame_q, ac_raw;
  logic [BUS_W-1:0]   ld_q, ld_pack;

  lcd_tick_div #(.DIV_W(DIV_W)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .limit_i (div_q),
    .tick_o  (tick)
  );

  lcd_bus_pack #(.BUS_W(BUS_W)) u_pack (
    .dual_i (dual_q),
    .wide_i (wide_q),
    .up_i   (up_pix_i),
    .lo_i   (lo_pix_i),
    .ld_o   (ld_pack)
  );

  lcd_ac_bias #(.AC_W(AC_W)) u_ac (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .frame_end_i (frame_end),
    .limit_i     (ac_q),
    .ac_o        (ac_raw)
  );

  always_comb begin
    unique case ({wide_q, dual_q})
      2'b10:   xfers = width_q >> SH_FULL;
      2'b11:   xfers = width_q >> SH_HALF;
      2'b00:   xfers = width_q >> SH_HALF;
      default: xfers = width_q >> SH_QTR;
    endcase
  end

  assign rows      = dual_q ? (height_q >> 1) : height_q;
  assign last_col  = (col_q == xfers - 1'b1);
  assign last_row  = (row_q == rows - 1'b1);
  assign data_ok   = up_valid_i && (lo_valid_i || !dual_q);
  assign fire      = (st_q == ST_DATA) && tick && data_ok;
  assign frame_end = (st_q == ST_GAP) && tick && last_row;
  assign cfg_load  = (st_q == ST_IDLE) || frame_end;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  st_d = ST_DATA;
      ST_DATA:  if (fire) st_d = ST_HOLD;
      ST_HOLD:  if (tick) st_d = ST_SHIFT;
      ST_SHIFT: if (tick) st_d = last_col ? ST_LOAD : ST_DATA;
      ST_LOAD:  if (tick) st_d = ST_GAP;
      ST_GAP:   if (tick) st_d = ST_DATA;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dual_q   <= 1'b0;
      wide_q   <= 1'b0;
      width_q  <= '0;
      height_q <= '0;
      div_q    <= '0;
      ac_q     <= '0;
    end else if (cfg_load) begin
      dual_q   <= dual_i;
      wide_q   <= bus_wide_i;
      width_q  <= panel_w_i;
      height_q <= panel_h_i;
      div_q    <= clk_div_i;
      ac_q     <= ac_frames_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      shift_q <= 1'b0;
      load_q  <= 1'b0;
      frame_q <= 1'b0;
      col_q   <= '0;
      row_q   <= '0;
      ld_q    <= '0;
    end else begin
      st_q    <= st_d;
      shift_q <= (st_d == ST_SHIFT);
      load_q  <= (st_d == ST_LOAD);
      if (fire) ld_q <= ld_pack;
      if ((st_q == ST_SHIFT) && tick) begin
        col_q <= last_col ? '0 : col_q + 1'b1;
        // frame strobe spans load of line 0 to load of line 1
        if (last_col) frame_q <= (row_q == '0);
      end
      if ((st_q == ST_GAP) && tick) row_q <= last_row ? '0 : row_q + 1'b1;
    end
  end

  assign up_ready_o = fire;
  assign lo_ready_o = fire && dual_q;
  assign shift_o    = shift_q ^ pol_shift_i;
  assign load_o     = load_q  ^ pol_load_i;
  assign frame_o    = frame_q ^ pol_frame_i;
  assign acb_o      = ac_raw  ^ pol_ac_i;
  assign ld_o       = ld_q;
endmodule

// File: rtl/lcd_passive_tgen_chk.sv
module lcd_passive_tgen_chk #(
  parameter int BUS_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             shift_act_i,
  input logic             load_act_i,
  input logic             frame_act_i,
  input logic             ac_act_i,
  input logic [BUS_W-1:0] ld_i,
  input logic             up_valid_i,
  input logic             up_ready_i,
  input logic             lo_valid_i,
  input logic             lo_ready_i
);
  AST_LD_STABLE_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_act_i |-> $stable(ld_i)); // R2
  AST_LOAD_GATES_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_act_i |-> !shift_act_i); // R11
  AST_BLANK_AFTER_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(load_act_i) |-> !shift_act_i); // R11
  AST_FRAME_RISE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frame_act_i) |-> $rose(load_act_i)); // R6
  AST_FRAME_FALL_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(frame_act_i) |-> $rose(load_act_i)); // R6
  AST_AC_IN_BLANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ac_act_i) |-> (!shift_act_i && !load_act_i)); // R7
  AST_LO_PAIRED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_ready_i |-> (up_ready_i && lo_valid_i)); // R5
  AST_READY_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_ready_i |-> up_valid_i); // R10
endmodule

bind lcd_passive_tgen lcd_passive_tgen_chk #(.BUS_W(BUS_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .shift_act_i (shift_q),
  .load_act_i  (load_q),
  .frame_act_i (frame_q),
  .ac_act_i    (ac_raw),
  .ld_i        (ld_o),
  .up_valid_i  (up_valid_i),
  .up_ready_i  (up_ready_o),
  .lo_valid_i  (lo_valid_i),
  .lo_ready_i  (lo_ready_o)
);

// File: tb/lcd_passive_tgen_bench.sv
module lcd_passive_tgen_bench;
  localparam int BUS_W = 8, W_W = 10, H_W = 10, DIV_W = 8, AC_W = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_dual = 1'b0, m_wide = 1'b1;
  logic [W_W-1:0] m_w = 10'd16;
  logic [H_W-1:0] cfg_h = 10'd4;
  logic [DIV_W-1:0] cfg_div = 8'd1;
  logic [AC_W-1:0] cfg_ac = 6'd2;
  logic pol_s = 0, pol_l = 0, pol_f = 0, pol_a = 0;
  logic [7:0] up_pix = 8'h0;
  logic [3:0] lo_pix = 4'h0;
  logic up_vld = 0, lo_vld = 0;
  logic up_rdy, lo_rdy, shift_o, load_o, frame_o, acb_o;
  logic [7:0] ld_o;

  lcd_passive_tgen u_lcd_passive_tgen (
    .clk_i(clk), .rst_ni(rst_n), .dual_i(m_dual), .bus_wide_i(m_wide),
    .panel_w_i(m_w), .panel_h_i(cfg_h), .clk_div_i(cfg_div), .ac_frames_i(cfg_ac),
    .pol_shift_i(pol_s), .pol_load_i(pol_l), .pol_frame_i(pol_f), .pol_ac_i(pol_a),
    .up_pix_i(up_pix), .up_valid_i(up_vld), .up_ready_o(up_rdy),
    .lo_pix_i(lo_pix), .lo_valid_i(lo_vld), .lo_ready_o(lo_rdy),
    .shift_o(shift_o), .load_o(load_o), .frame_o(frame_o), .acb_o(acb_o), .ld_o(ld_o)
  );

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_pack(logic d, logic wd, logic [7:0] u, logic [3:0] l);
    if (!d && wd) return u;
    if (!d)       return {4'h0, u[3:0]};
    if (wd)       return {u[3:0], l};
    return {4'h0, u[1:0], l[1:0]};
  endfunction

  function automatic int exp_xfers(logic d, logic wd, int w);
    int ppt;
    ppt = wd ? (d ? 4 : 8) : (d ? 2 : 4);
    return w / ppt;
  endfunction

  function automatic int exp_rows(logic d, int h);
    return d ? h / 2 : h;
  endfunction

  function automatic int eff_ac(int a);
    return (a == 0) ? 1 : a;
  endfunction

  // bench's view of the configuration in force
  int cur_h, cur_div, cur_ac, pend_h, pend_div, pend_ac;
  bit has_pend = 0;

  // pixel sources
  logic [7:0] exp_q[$];
  bit src_en = 0, fire_prev = 0;
  int lo_single = 0, lo_dual = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      up_vld = 0; lo_vld = 0; fire_prev = 0;
    end else begin
      if (fire_prev) begin
        up_vld = 0;
        if (m_dual) lo_vld = 0;
        fire_prev = 0;
      end
      if (src_en && !up_vld && ($urandom_range(3) != 0)) begin up_vld = 1; up_pix = 8'($urandom); end
      if (src_en && !lo_vld && ($urandom_range(3) != 0)) begin lo_vld = 1; lo_pix = 4'($urandom); end
      #1;
      if (up_rdy) begin
        exp_q.push_back(exp_pack(m_dual, m_wide, up_pix, lo_pix));
        fire_prev = 1;
      end
      if (lo_rdy && !m_dual) lo_single++;
      if (lo_rdy && m_dual) lo_dual++;
    end
  end

  // output monitor
  bit p_sh, p_ld, p_fr, p_ac, seen_fr;
  int sh_w, ld_w, line_shifts, lcount, frame_rows, frame_ac, since_ac;
  int frames = 0, n_shift = 0, last_frame_loads = 0, n_ac = 0;
  logic [7:0] ld_at_rise;

  always @(negedge clk) begin
    bit sh, ld, fr, ac;
    logic [7:0] e;
    if (!rst_n) begin
      p_sh = 0; p_ld = 0; p_fr = 0; p_ac = 0; seen_fr = 0;
      sh_w = 0; ld_w = 0; line_shifts = 0; lcount = 0; since_ac = 0;
    end else begin
      sh = shift_o ^ pol_s; ld = load_o ^ pol_l; fr = frame_o ^ pol_f; ac = acb_o ^ pol_a;
      if (sh && !p_sh) begin
        n_shift++; line_shifts++; ld_at_rise = ld_o;
        if (exp_q.size() == 0) chk(0, "R10", "shift without accepted word", 1, 0);
        else begin
          e = exp_q.pop_front();
          chk(ld_o == e, "R4", "bus word at shift", ld_o, e);
        end
      end
      if (sh) sh_w++;
      if (!sh && p_sh) begin
        chk(sh_w == cur_div + 1, "R2", "shift active width", sh_w, cur_div + 1);
        chk(ld_o == ld_at_rise, "R2", "bus held during shift", ld_o, ld_at_rise);
        sh_w = 0;
      end
      if (fr != p_fr) chk(ld && !p_ld, "R6", "frame edge on load rise", ld, 1);
      if (ld && !p_ld) begin
        chk(!sh, "R11", "shift inactive at load", sh, 0);
        chk(line_shifts == exp_xfers(m_dual, m_wide, m_w), "R3", "shifts per line",
            line_shifts, exp_xfers(m_dual, m_wide, m_w));
        line_shifts = 0;
        if (fr && !p_fr) begin
          if (seen_fr) begin
            chk(lcount == frame_rows, "R6", "loads per frame", lcount, frame_rows);
            last_frame_loads = lcount;
          end
          seen_fr = 1; lcount = 1;
          frame_rows = exp_rows(m_dual, cur_h);
          frame_ac = eff_ac(cur_ac);
          frames++; since_ac++;
        end else lcount++;
      end
      if (ld) ld_w++;
      if (!ld && p_ld) begin
        chk(ld_w == cur_div + 1, "R11", "load active width", ld_w, cur_div + 1);
        ld_w = 0;
        if (lcount == frame_rows && has_pend) begin
          cur_h = pend_h; cur_div = pend_div; cur_ac = pend_ac; has_pend = 0;
        end
      end
      if (ac != p_ac) begin
        chk(since_ac == frame_ac, "R7", "frames per AC toggle", since_ac, frame_ac);
        since_ac = 0; n_ac++;
      end
      p_sh = sh; p_ld = ld; p_fr = fr; p_ac = ac;
    end
  end

  task automatic wait_frames(int n);
    int t;
    t = frames + n;
    while (frames < t) @(negedge clk);
  endtask

  task automatic start_phase(logic d, logic wd, int w, int h, int dv, int a, logic pol, string req);
    src_en = 0;
    @(negedge clk);
    rst_n = 0;
    m_dual = d; m_wide = wd; m_w = W_W'(w);
    cfg_h = H_W'(h); cfg_div = DIV_W'(dv); cfg_ac = AC_W'(a);
    pol_s = pol; pol_l = pol; pol_f = pol; pol_a = pol;
    cur_h = h; cur_div = dv; cur_ac = a; has_pend = 0;
    lo_single = 0; lo_dual = 0;
    exp_q.delete();
    repeat (3) @(negedge clk);
    chk(shift_o == pol, req, "reset shift level", shift_o, pol);
    chk(load_o == pol, req, "reset load level", load_o, pol);
    chk(frame_o == pol, req, "reset frame level", frame_o, pol);
    chk(acb_o == pol, req, "reset AC level", acb_o, pol);
    chk(ld_o == 8'h0, "R1", "reset bus", ld_o, 0);
    chk(!up_rdy && !lo_rdy, "R1", "reset ready", up_rdy | lo_rdy, 0);
    rst_n = 1;
    src_en = 1;
  endtask

  initial begin
    int rec, old_rows, new_rows;
    void'($urandom(32'h5eed_1cd0));
    // single wide, stall test
    start_phase(0, 1, 16, 4, 1, 2, 0, "R1");
    wait_frames(6);
    chk(n_ac >= 2, "R7", "AC toggles seen", n_ac, 2);
    src_en = 0;
    repeat (40) @(negedge clk);
    rec = n_shift;
    repeat (120) @(negedge clk);
    chk(n_shift == rec, "R10", "no shift while starved", n_shift, rec);
    src_en = 1;
    repeat (60) @(negedge clk);
    chk(n_shift > rec, "R10", "shifting resumes", n_shift, rec + 1);
    chk(lo_single == 0, "R5", "lower accepts in single mode", lo_single, 0);

    // single narrow, all outputs active-low, AC count 0
    start_phase(0, 0, 24, 3, 0, 0, 1, "R8");
    wait_frames(5);
    chk(lo_single == 0, "R5", "lower accepts in single mode", lo_single, 0);

    // dual wide
    start_phase(1, 1, 16, 6, 2, 3, 0, "R1");
    wait_frames(7);
    chk(lo_dual > 0, "R5", "lower accepts in dual mode", lo_dual, 1);

    // dual narrow, mid-frame reconfiguration
    start_phase(1, 0, 8, 4, 1, 1, 0, "R1");
    wait_frames(2);
    repeat (3) @(negedge clk);
    old_rows = exp_rows(1, cur_h);
    new_rows = exp_rows(1, 8);
    cfg_h = 10'd8; cfg_div = 8'd3; cfg_ac = 6'd2;
    pend_h = 8; pend_div = 3; pend_ac = 2; has_pend = 1;
    wait_frames(1);
    chk(last_frame_loads == old_rows, "R9", "frame in progress keeps height", last_frame_loads, old_rows);
    wait_frames(1);
    chk(last_frame_loads == new_rows, "R9", "next frame uses new height", last_frame_loads, new_rows);
    wait_frames(4);
    chk(cur_div == 3, "R9", "divider switched at boundary", cur_div, 3);
    chk(lo_dual > 0, "R5", "lower accepts in dual mode", lo_dual, 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog (all requirements): actual %0d cycles expected fewer", 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule